// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block sits between a host CPU and a secure co-processor. The host stages sixteen argument words in registers, then writes a command word. That command write is atomic: the command and a snapshot of all sixteen arguments enter a small command queue as one entry. The co-processor takes entries from the head of the queue through a valid/pop interface. It hands results back through a one-cycle completion strobe that loads a return word and sixteen result words at once.

Three interrupt causes are tracked in a sticky status register:
- a command has completed;
- a command write was attempted while the queue was full;
- the queue has become full.

Software clears causes by writing ones. Each cause can be masked, and all three are masked after reset. A single level interrupt output is the OR of every cause that is set and not masked. Host reads are combinational from the address. Writes take effect at the clock edge.

Top module: `mbx_host_mailbox`

## Requirements
- R1: After reset the argument, return, result and interrupt status registers read zero. The mask register at 0xCC reads 0x0006_0001. The queue is empty, `irq_o` is low and `cq_valid_o` is low.
- R2: Argument word i (i = 0..15) is written and read back at byte offset 4*i.
- R3: A host write to 0x40 enqueues the written command with the argument values held before that write. Later argument writes do not alter queued entries. Entries leave in FIFO order on `cq_cmd_o`/`cq_args_o`, with argument i at bits [32*i+31:32*i].
- R4: Offset 0xC4 reads the queue occupancy in bits 2:0 and `cp_ready_i` in bit 8. All other bits read zero.
- R5: A command write is dropped when the occupancy at the start of that cycle is 4, even if a pop happens in the same cycle. A dropped write sets status bits 17 and 18 and leaves the queue untouched.
- R6: An accepted command write that raises the occupancy from 3 to 4, with no pop in the same cycle, sets status bit 18 only.
- R7: A cycle with `cpl_valid_i` high loads the return word (read at 0x80) and result word i (read at 0x84 + 4*i) together, and sets status bit 0.
- R8: The status register at 0xC8 is write-one-to-clear. Written ones clear those bits, and written zeros leave bits unchanged. If a cause is set and cleared in the same cycle, the set wins.
- R9: The mask register at 0xCC stores only bits 0, 17 and 18. A set bit masks that cause. `irq_o` is high exactly when some status bit is set with its mask bit clear.
- R10: Reads of unmapped or misaligned offsets return zero, and so do reads of the command register. Writes to 0x80..0xC4 and to unmapped or misaligned offsets change nothing.
- R11: `cq_valid_o` is high exactly when the queue is non-empty. A pop while the queue is empty is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe, one write per cycle |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Combinational read data for `host_addr` |
| irq_o | output | 1 | Level interrupt to the host |
| cp_ready_i | input | 1 | Co-processor ready flag, shown in queue status |
| cq_valid_o | output | 1 | Queue head is valid |
| cq_pop_i | input | 1 | Co-processor removes the head entry |
| cq_cmd_o | output | 32 | Command word of the head entry |
| cq_args_o | output | 512 | Sixteen argument words of the head entry |
| cpl_valid_i | input | 1 | Completion strobe |
| cpl_ret_i | input | 32 | Return word delivered with the completion |
| cpl_status_i | input | 512 | Sixteen result words delivered with the completion |

## Verification
The embedded properties assume that `host_we`, `cq_pop_i` and `cpl_valid_i` are known after reset. They also assume that a mask write and a cause event may coincide, and the interrupt property excludes that cycle. The bench drives every input once per cycle at the falling edge and never leaves a strobe undefined. It is allowed to pop an empty queue and to write the command register while the queue is full, because those cases are defined behaviour. Random traffic mixes argument, command, clear, mask and stray writes with pops and completions. Directed steps cover a pop and a command write in the same cycle while the queue is full, and a completion that lands in the same cycle as a clear.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    parameter int DW    = 32;
    parameter int NARGS = 16;
    localparam int AW   = 8;
    localparam int IW   = $clog2(NARGS);

    typedef logic [DW-1:0] word_t;
    typedef logic [AW-1:0] addr_t;

    // register offsets
    localparam addr_t OFS_CMD   = 8'h40;
    localparam addr_t OFS_RET   = 8'h80;
    localparam addr_t OFS_RES0  = 8'h84;
    localparam addr_t OFS_QSTAT = 8'hC4;
    localparam addr_t OFS_ICLR  = 8'hC8;
    localparam addr_t OFS_IMSK  = 8'hCC;
    localparam addr_t ARG_END   = addr_t'(NARGS * 4);
    localparam addr_t RES_END   = OFS_RES0 + addr_t'(NARGS * 4);

    // interrupt cause and status bit positions
    localparam int BIT_DONE  = 0;
    localparam int BIT_QHIT  = 17;
    localparam int BIT_QFULL = 18;
    localparam int BIT_RDY   = 8;

    localparam word_t CAUSE_MASK = (word_t'(1) << BIT_DONE)
                                 | (word_t'(1) << BIT_QHIT)
                                 | (word_t'(1) << BIT_QFULL);

    typedef struct packed {
        word_t [NARGS-1:0] args;
        word_t             cmd;
    } cmd_entry_t;
endpackage

// File: rtl/mbx_cmd_queue.sv
module mbx_cmd_queue
    import mbx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push_i,
    input  cmd_entry_t                   push_data_i,
    input  logic                         pop_i,
    output cmd_entry_t                   head_o,
    output logic                         valid_o,
    output logic                         full_o,
    output logic [$clog2(DEPTH+1)-1:0]   count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        cmd_entry_t [DEPTH-1:0] mem;
        logic [PW-1:0]          wp;
        logic [PW-1:0]          rp;
        logic [CW-1:0]          cnt;
    } q_state_t;

    q_state_t q_q, q_d;
    logic     do_push, do_pop;

    always_comb begin
        q_d     = q_q;
        do_push = push_i && (q_q.cnt != CW'(DEPTH));
        do_pop  = pop_i && (q_q.cnt != '0);
        if (do_push) begin
            q_d.mem[q_q.wp] = push_data_i;
            q_d.wp = (q_q.wp == PW'(DEPTH - 1)) ? '0 : q_q.wp + 1'b1;
        end
        if (do_pop) begin
            q_d.rp = (q_q.rp == PW'(DEPTH - 1)) ? '0 : q_q.rp + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   q_d.cnt = q_q.cnt + 1'b1;
            2'b01:   q_d.cnt = q_q.cnt - 1'b1;
            default: q_d.cnt = q_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_o  = q_q.mem[q_q.rp];
    assign valid_o = (q_q.cnt != '0);
    assign full_o  = (q_q.cnt == CW'(DEPTH));
    assign count_o = q_q.cnt;

    // R5
    depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push_i && full_o && !pop_i |=> $stable(count_o) && full_o);

    // R11
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i && !valid_o && !push_i |=> !valid_o);
endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
    import mbx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  word_t set_i,
    input  logic  clr_we_i,
    input  logic  mask_we_i,
    input  word_t wdata_i,
    output word_t status_o,
    output word_t mask_o,
    output logic  irq_o
);
    typedef struct packed {
        word_t status;
        word_t mask;
    } irq_state_t;

    irq_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (clr_we_i)  st_d.status = st_q.status & ~wdata_i;
        st_d.status = (st_d.status | set_i) & CAUSE_MASK;
        if (mask_we_i) st_d.mask = wdata_i & CAUSE_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{status: '0, mask: CAUSE_MASK};
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign mask_o   = st_q.mask;
    assign irq_o    = |(st_q.status & ~st_q.mask);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we_i && wdata_i[BIT_DONE] && !set_i[BIT_DONE] |=> !status_o[BIT_DONE]);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[BIT_QFULL] |=> status_o[BIT_QFULL]);

    // R9
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[BIT_DONE] && !mask_o[BIT_DONE] && !mask_we_i |=> irq_o);
endmodule

// File: rtl/mbx_host_mailbox.sv
module mbx_host_mailbox
    import mbx_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_we,
    input  logic [7:0]           host_addr,
    input  logic [31:0]          host_wdata,
    output logic [31:0]          host_rdata,
    output logic                 irq_o,
    input  logic                 cp_ready_i,
    output logic                 cq_valid_o,
    input  logic                 cq_pop_i,
    output logic [31:0]          cq_cmd_o,
    output logic [NARGS*DW-1:0]  cq_args_o,
    input  logic                 cpl_valid_i,
    input  logic [31:0]          cpl_ret_i,
    input  logic [NARGS*DW-1:0]  cpl_status_i
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [IW-1:0] RES_BASE_IDX = OFS_RES0[IW+1:2];

    typedef struct packed {
        word_t [NARGS-1:0] args;
        word_t             ret;
        word_t [NARGS-1:0] res;
    } regs_t;

    regs_t st_q, st_d;

    logic          aligned, is_arg, is_cmd, is_ret, is_res, is_qstat, is_iclr, is_imsk;
    logic [IW-1:0] arg_idx, res_idx;
    logic          cmd_wr, q_full, q_valid, pop_eff, push_ok;
    logic [CW-1:0] q_count;
    cmd_entry_t    q_head, q_push;
    word_t         cause_set, irq_status, irq_mask, qstat_word;

    // address decode
    always_comb begin
        aligned  = (host_addr[1:0] == 2'b00);
        is_arg   = aligned && (host_addr < ARG_END);
        is_cmd   = aligned && (host_addr == OFS_CMD);
        is_ret   = aligned && (host_addr == OFS_RET);
        is_res   = aligned && (host_addr >= OFS_RES0) && (host_addr < RES_END);
        is_qstat = aligned && (host_addr == OFS_QSTAT);
        is_iclr  = aligned && (host_addr == OFS_ICLR);
        is_imsk  = aligned && (host_addr == OFS_IMSK);
        arg_idx  = host_addr[IW+1:2];
        res_idx  = host_addr[IW+1:2] - RES_BASE_IDX;
    end

    // queue control and cause generation
    always_comb begin
        cmd_wr      = host_we && is_cmd;
        pop_eff     = cq_pop_i && q_valid;
        push_ok     = cmd_wr && !q_full;
        q_push.cmd  = host_wdata;
        q_push.args = st_q.args;
        cause_set   = '0;
        cause_set[BIT_DONE]  = cpl_valid_i;
        cause_set[BIT_QHIT]  = cmd_wr && q_full;
        cause_set[BIT_QFULL] = (cmd_wr && q_full)
                            || (push_ok && (q_count == CW'(DEPTH - 1)) && !pop_eff);
    end

    // register next state
    always_comb begin
        st_d = st_q;
        if (host_we && is_arg) st_d.args[arg_idx] = host_wdata;
        if (cpl_valid_i) begin
            st_d.ret = cpl_ret_i;
            st_d.res = cpl_status_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // read mux
    always_comb begin
        qstat_word          = '0;
        qstat_word[BIT_RDY] = cp_ready_i;
        qstat_word[CW-1:0]  = q_count;
        host_rdata = '0;
        if (is_arg)        host_rdata = st_q.args[arg_idx];
        else if (is_ret)   host_rdata = st_q.ret;
        else if (is_res)   host_rdata = st_q.res[res_idx];
        else if (is_qstat) host_rdata = qstat_word;
        else if (is_iclr)  host_rdata = irq_status;
        else if (is_imsk)  host_rdata = irq_mask;
    end

    mbx_cmd_queue #(.DEPTH(DEPTH)) i_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (cmd_wr),
        .push_data_i (q_push),
        .pop_i       (cq_pop_i),
        .head_o      (q_head),
        .valid_o     (q_valid),
        .full_o      (q_full),
        .count_o     (q_count)
    );

    mbx_irq_ctrl i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (cause_set),
        .clr_we_i  (host_we && is_iclr),
        .mask_we_i (host_we && is_imsk),
        .wdata_i   (host_wdata),
        .status_o  (irq_status),
        .mask_o    (irq_mask),
        .irq_o     (irq_o)
    );

    assign cq_valid_o = q_valid;
    assign cq_cmd_o   = q_head.cmd;
    assign cq_args_o  = q_head.args;

    // R7
    ret_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpl_valid_i |=> st_q.ret == $past(cpl_ret_i) && irq_status[BIT_DONE]);

    // R7
    ret_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cpl_valid_i |=> $stable(st_q.ret));

    // R6
    fill_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && (q_count == CW'(DEPTH - 1)) && !cq_pop_i |=> irq_status[BIT_QFULL] && q_full);

    // R5
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && q_full |=> irq_status[BIT_QHIT] && irq_status[BIT_QFULL]);
endmodule

// File: tb/test_mbx_host_mailbox.sv
`timescale 1ns/1ps
module test_mbx_host_mailbox;
    localparam int NA  = 16;
    localparam int DEP = 4;
    localparam logic [31:0] CMASK = 32'h0006_0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              host_we = 1'b0;
    logic [7:0]        host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              irq_o;
    logic              cp_ready_i = 1'b0;
    logic              cq_valid_o;
    logic              cq_pop_i = 1'b0;
    logic [31:0]       cq_cmd_o;
    logic [NA*32-1:0]  cq_args_o;
    logic              cpl_valid_i = 1'b0;
    logic [31:0]       cpl_ret_i = '0;
    logic [NA*32-1:0]  cpl_status_i = '0;

    mbx_host_mailbox #(.DEPTH(DEP)) i_mbx_host_mailbox (.*);

    int total = 0;
    int bad = 0;

    // bench model
    logic [31:0] m_args [NA];
    logic [31:0] m_qcmd [DEP];
    logic [31:0] m_qargs [DEP][NA];
    int          m_head = 0;
    int          m_cnt = 0;
    logic [31:0] m_stat = '0;
    logic [31:0] m_mask = CMASK;
    logic [31:0] m_ret = '0;
    logic [31:0] m_res [NA];
    logic [31:0] cv [NA];

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        if (a[1:0] != 2'b00) return '0;
        if (a < 8'h40) return m_args[a[5:2]];
        if (a == 8'h80) return m_ret;
        if (a >= 8'h84 && a < 8'hC4) return m_res[(a - 8'h84) >> 2];
        if (a == 8'hC4) return {23'b0, cp_ready_i, 5'b0, 3'(m_cnt)};
        if (a == 8'hC8) return m_stat;
        if (a == 8'hCC) return m_mask;
        return '0;
    endfunction

    function automatic string req_of(input logic [7:0] a);
        if (a[1:0] != 2'b00) return "R10";
        if (a < 8'h40) return "R2";
        if (a >= 8'h80 && a < 8'hC4) return "R7";
        if (a == 8'hC4) return "R4";
        if (a == 8'hC8) return "R8";
        if (a == 8'hCC) return "R9";
        return "R10";
    endfunction

    function automatic logic exp_irq();
        return |(m_stat & ~m_mask);
    endfunction

    task automatic rd_chk(input logic [7:0] a, input string tag);
        @(negedge clk);
        host_we = 1'b0;
        host_addr = a;
        #1;
        chk((tag == "") ? req_of(a) : tag, $sformatf("read %h", a), host_rdata, exp_rd(a));
    endtask

    task automatic check_all(input string tag);
        for (int a = 0; a <= 'hD0; a += 4) rd_chk(8'(a), tag);
        rd_chk(8'h41, "R10");
        rd_chk(8'hFC, "R10");
    endtask

    function automatic void model_apply(input logic we, input logic [7:0] a, input logic [31:0] d,
                                        input logic pop, input logic cpl);
        int   pc = m_cnt;
        logic popeff = pop && (pc > 0);
        logic pushed = 1'b0;
        logic [31:0] setv = '0;
        logic al = (a[1:0] == 2'b00);
        if (we && al && a == 8'hC8) m_stat = m_stat & ~d;
        if (we && al && a == 8'hCC) m_mask = d & CMASK;
        if (we && al && a < 8'h40) m_args[a[5:2]] = d;
        if (we && al && a == 8'h40) begin
            if (pc == DEP) setv |= 32'h0006_0000;
            else begin
                int t = (m_head + pc) % DEP;
                m_qcmd[t] = d;
                for (int i = 0; i < NA; i++) m_qargs[t][i] = m_args[i];
                pushed = 1'b1;
                if (pc == DEP - 1 && !popeff) setv |= 32'h0004_0000;
            end
        end
        if (popeff) m_head = (m_head + 1) % DEP;
        m_cnt = pc + int'(pushed) - int'(popeff);
        if (cpl) begin
            m_ret = cpl_ret_i;
            for (int i = 0; i < NA; i++) m_res[i] = cv[i];
            setv |= 32'h1;
        end
        m_stat = m_stat | setv;
    endfunction

    task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                        input logic pop, input logic cpl);
        @(negedge clk);
        host_we = we;
        host_addr = a;
        host_wdata = d;
        cq_pop_i = pop;
        cpl_valid_i = cpl;
        for (int i = 0; i < NA; i++) cpl_status_i[i*32 +: 32] = cv[i];
        #1;
        // R11
        chk("R11", "cq_valid", 32'(cq_valid_o), 32'(m_cnt != 0));
        if (pop && m_cnt > 0) begin
            chk("R3", "head cmd", cq_cmd_o, m_qcmd[m_head]);
            for (int i = 0; i < NA; i++)
                chk("R3", $sformatf("head arg%0d", i), cq_args_o[i*32 +: 32], m_qargs[m_head][i]);
        end
        @(posedge clk);
        model_apply(we, a, d, pop, cpl);
        #1;
        host_we = 1'b0;
        cq_pop_i = 1'b0;
        cpl_valid_i = 1'b0;
        // R9
        chk("R9", "irq_o", 32'(irq_o), 32'(exp_irq()));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(1'b1, a, d, 1'b0, 1'b0);
    endtask

    task automatic complete(input logic [31:0] r);
        cpl_ret_i = r;
        for (int i = 0; i < NA; i++) cv[i] = $urandom;
        step(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
    endtask

    initial begin
        #(4 * 150000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NA; i++) begin
            m_args[i] = '0;
            m_res[i] = '0;
            cv[i] = '0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check_all("R1");
        chk("R1", "irq after reset", 32'(irq_o), 32'h0);
        chk("R1", "valid after reset", 32'(cq_valid_o), 32'h0);
        cp_ready_i = 1'b1;
        rd_chk(8'hC4, "R4");

        // R2: argument registers
        for (int i = 0; i < NA; i++) wr(8'(4 * i), 32'hA000_0000 + 32'(i));
        check_all("");

        // R6 / R5: fill, then overflow
        wr(8'hCC, 32'h0);
        for (int k = 0; k < DEP; k++) begin
            wr(8'h40, 32'hC0DE_0000 + 32'(k));
            wr(8'h00, 32'h1111_0000 + 32'(k));
        end
        rd_chk(8'hC8, "R6");
        rd_chk(8'hC4, "R4");
        wr(8'hC8, 32'hFFFF_FFFF);
        wr(8'h40, 32'hDEAD_0001);
        rd_chk(8'hC8, "R5");
        rd_chk(8'hC4, "R5");

        // R5: pop and command write in the same full cycle
        step(1'b1, 8'h40, 32'hDEAD_0002, 1'b1, 1'b0);
        rd_chk(8'hC4, "R5");
        rd_chk(8'hC8, "R5");

        // R3: drain in order, args snapshot unaffected by later writes
        for (int i = 0; i < NA; i++) wr(8'(4 * i), 32'h5555_0000 + 32'(i));
        while (m_cnt > 0) step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
        // R11: pop on empty queue
        step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
        rd_chk(8'hC4, "R11");

        // R7 and R8
        wr(8'hC8, 32'hFFFF_FFFF);
        complete(32'h0BAD_F00D);
        check_all("R7");
        wr(8'hC8, 32'h0004_0000);
        rd_chk(8'hC8, "R8");
        cpl_ret_i = 32'h1234_5678;
        for (int i = 0; i < NA; i++) cv[i] = 32'(i * 3);
        step(1'b1, 8'hC8, 32'h0000_0001, 1'b0, 1'b1);
        rd_chk(8'hC8, "R8");
        rd_chk(8'h80, "R7");

        // R9: masking
        wr(8'hCC, 32'hFFFF_FFFF);
        rd_chk(8'hCC, "R9");
        wr(8'hCC, 32'h0000_0000);
        wr(8'hC8, 32'h0000_0001);
        rd_chk(8'hC8, "R9");

        // R10: read-only and unmapped writes ignored
        wr(8'h80, 32'hFFFF_FFFF);
        wr(8'h88, 32'hFFFF_FFFF);
        wr(8'hC4, 32'hFFFF_FFFF);
        wr(8'hD4, 32'hFFFF_FFFF);
        wr(8'h05, 32'hFFFF_FFFF);
        check_all("R10");

        // random traffic
        for (int it = 0; it < 600; it++) begin
            int sel = int'($urandom % 100);
            if (sel < 35)      wr(8'(4 * ($urandom % NA)), $urandom);
            else if (sel < 52) wr(8'h40, $urandom);
            else if (sel < 68) step(1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
            else if (sel < 76) complete($urandom);
            else if (sel < 84) wr(8'hC8, $urandom);
            else if (sel < 89) wr(8'hCC, $urandom);
            else if (sel < 95) wr(8'($urandom), $urandom);
            else begin
                @(negedge clk);
                cp_ready_i = ~cp_ready_i;
            end
            if (it % 25 == 0) check_all("");
        end
        check_all("");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule